// File: doc/BRIEF.md
# LCD Horizontal Line Timing Generator

This block paces one display line at a time from a 32-bit control word. Each line passes through four phases in a fixed order: a wait before the first pixel, the run of active pixels, a wait after the last pixel, and the line clock (horizontal sync) pulse. While enabled, lines follow one another with no gap. One core clock cycle stands for one pixel clock period. The block drives a pixel-clock enable, a pixel-valid strobe, the line clock and a one-cycle end-of-line pulse that a vertical counter can count.

A mode input picks the display style. In passive mode the pixel clock enable is high only while pixels are sent. In active mode it stays high in every phase. The control word is written and read through a plain register port. Writes land only while the block is disabled. Each count field has a fixed offset added to it, and the low four bits of the pixel count are hard-wired to zero.

Top module: `lcd_line_timer`

## Requirements
- R1: The control word holds the pixel count in bits 9..0, the sync width in bits 15..10, the end wait in bits 23..16 and the start wait in bits 31..24. `cfg_rdata` returns the stored word with bits 3..0 always zero, whatever was written there.
- R2: After reset, `cfg_rdata` is zero and all four timing outputs are low.
- R3: A write made while `ctl_enable` is 1 leaves the stored word and the line timing unchanged.
- R4: Each line opens with start-wait + 1 cycles in which `pix_valid` and `line_clk` are low.
- R5: `pix_valid` is then high for (pixel count with bits 3..0 cleared) + 16 consecutive cycles.
- R6: After the last pixel, end-wait + 1 cycles follow with `pix_valid` and `line_clk` low.
- R7: `line_clk` is then high for sync-width + 2 consecutive cycles.
- R8: `eol_pulse` is high for exactly one cycle, the last cycle of the `line_clk` pulse.
- R9: With `active_mode` = 0, `pclk_en` is high exactly when `pix_valid` is high.
- R10: With `active_mode` = 1 and the block enabled, `pclk_en` is high in every cycle.
- R11: While `ctl_enable` is 0, all timing outputs are low. Once re-enabled, the block always starts again at the first cycle of the start wait.
- R12: While enabled, each line begins in the cycle right after the previous line's `eol_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one cycle per pixel clock period |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_enable | input | 1 | Runs the line sequencer; blocks writes to the control word when high |
| active_mode | input | 1 | 1 = free-running pixel clock, 0 = gated pixel clock |
| cfg_wr_en | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word to write |
| cfg_rdata | output | 32 | Stored control word |
| pclk_en | output | 1 | Pixel clock enable |
| pix_valid | output | 1 | High while active pixels are output |
| line_clk | output | 1 | Line clock (horizontal sync) pulse |
| eol_pulse | output | 1 | One-cycle end-of-line marker |

## Verification
Two pairs of functions can fall in the same cycle. The end-of-line marker coincides with the last cycle of the sync pulse. A register write can also arrive while a line is being timed. The first pair is exercised with the shortest fields, where the two-cycle sync pulse makes the marker land right next to the pulse's rising edge. Each cycle is then judged against a per-cycle expected stream. For the second pair, the bench issues a write in the middle of a running line. It then checks that the rest of the line and the next line keep the old lengths, and that the read-back word is unchanged after disabling.

// File: rtl/lcd_line_pkg.sv
package lcd_line_pkg;

  // field widths of the control word, lowest field first
  localparam int PPL_W        = 10;
  localparam int HSW_W        = 6;
  localparam int ELW_W        = 8;
  localparam int BLW_W        = 8;
  localparam int WORD_W       = PPL_W + HSW_W + ELW_W + BLW_W;

  // pixel-count bits that are hard-wired to zero
  localparam int PPL_LSB_DROP = 4;

  // constant offsets added to each field
  localparam int PIX_BASE     = 16;
  localparam int HSW_BASE     = 2;
  localparam int ELW_BASE     = 1;
  localparam int BLW_BASE     = 1;

  // phase counter must hold the longest phase minus one
  localparam int MAX_PHASE    = (1 << PPL_W) - (1 << PPL_LSB_DROP) + PIX_BASE;
  localparam int CNT_W        = $clog2(MAX_PHASE);

  typedef enum logic [1:0] {
    PH_BOL  = 2'd0,
    PH_PIX  = 2'd1,
    PH_EOL  = 2'd2,
    PH_SYNC = 2'd3
  } phase_e;

  typedef struct packed {
    logic [BLW_W-1:0] blw;
    logic [ELW_W-1:0] elw;
    logic [HSW_W-1:0] hsw;
    logic [PPL_W-1:0] ppl;
  } line_cfg_t;

  // strip the unimplemented pixel-count bits from a raw word
  function automatic line_cfg_t sanitize(input logic [WORD_W-1:0] w);
    line_cfg_t c;
    c = line_cfg_t'(w);
    c.ppl[PPL_LSB_DROP-1:0] = '0;
    return c;
  endfunction

  // number of cycles a phase lasts
  function automatic int phase_len(input line_cfg_t c, input phase_e p);
    int n;
    case (p)
      PH_BOL:  n = int'(c.blw) + BLW_BASE;
      PH_PIX:  n = int'(c.ppl) + PIX_BASE;
      PH_EOL:  n = int'(c.elw) + ELW_BASE;
      default: n = int'(c.hsw) + HSW_BASE;
    endcase
    return n;
  endfunction

  // terminal count of the up-counter within a phase
  function automatic logic [CNT_W-1:0] phase_last(input line_cfg_t c, input phase_e p);
    return CNT_W'(phase_len(c, p) - 1);
  endfunction

  function automatic phase_e next_phase(input phase_e p);
    phase_e n;
    case (p)
      PH_BOL:  n = PH_PIX;
      PH_PIX:  n = PH_EOL;
      PH_EOL:  n = PH_SYNC;
      default: n = PH_BOL;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/lcd_cfg_reg.sv
module lcd_cfg_reg
  import lcd_line_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_enable,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output line_cfg_t         cfg,
  output logic [WORD_W-1:0] rdata,
  output logic              wr_accept
);

  line_cfg_t cfg_q;

  // writes only land while the sequencer is stopped
  assign wr_accept = wr_en && !ctl_enable;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_accept) begin
      cfg_q <= sanitize(wdata);
    end
  end

  assign cfg   = cfg_q;
  assign rdata = cfg_q;

endmodule

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq
  import lcd_line_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  line_cfg_t        cfg,
  output phase_e           phase,
  output logic [CNT_W-1:0] cnt,
  output logic             phase_end
);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last      = phase_last(cfg, phase_q);
  assign phase_end = run && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      phase_q <= PH_BOL;
      cnt_q   <= '0;
    end else if (phase_end) begin
      phase_q <= next_phase(phase_q);
      cnt_q   <= '0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign phase = phase_q;
  assign cnt   = cnt_q;

endmodule

// File: rtl/lcd_out_decode.sv
module lcd_out_decode
  import lcd_line_pkg::*;
(
  input  logic   run,
  input  logic   active_mode,
  input  phase_e phase,
  input  logic   phase_end,
  output logic   pclk_en,
  output logic   pix_valid,
  output logic   line_clk,
  output logic   eol_pulse
);

  logic in_pix;
  logic in_sync;

  assign in_pix    = (phase == PH_PIX);
  assign in_sync   = (phase == PH_SYNC);

  assign pix_valid = run && in_pix;
  assign line_clk  = run && in_sync;
  assign eol_pulse = line_clk && phase_end;
  assign pclk_en   = run && (active_mode || in_pix);

endmodule

// File: rtl/lcd_line_timer.sv
module lcd_line_timer
  import lcd_line_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_enable,
  input  logic        active_mode,
  input  logic        cfg_wr_en,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        pclk_en,
  output logic        pix_valid,
  output logic        line_clk,
  output logic        eol_pulse
);

  line_cfg_t        cfg;
  phase_e           phase;
  logic [CNT_W-1:0] phase_cnt;

  // named internal events
  logic evt_phase_end;
  logic evt_wr_accept;
  logic evt_line_wrap;

  lcd_cfg_reg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_enable (ctl_enable),
    .wr_en      (cfg_wr_en),
    .wdata      (cfg_wdata),
    .cfg        (cfg),
    .rdata      (cfg_rdata),
    .wr_accept  (evt_wr_accept)
  );

  lcd_phase_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ctl_enable),
    .cfg       (cfg),
    .phase     (phase),
    .cnt       (phase_cnt),
    .phase_end (evt_phase_end)
  );

  lcd_out_decode u_dec (
    .run         (ctl_enable),
    .active_mode (active_mode),
    .phase       (phase),
    .phase_end   (evt_phase_end),
    .pclk_en     (pclk_en),
    .pix_valid   (pix_valid),
    .line_clk    (line_clk),
    .eol_pulse   (eol_pulse)
  );

  assign evt_line_wrap = eol_pulse;

endmodule

// File: rtl/lcd_line_timer_chk.sv
module lcd_line_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ctl_enable,
  input logic        active_mode,
  input logic        cfg_wr_en,
  input logic [31:0] cfg_rdata,
  input logic        pclk_en,
  input logic        pix_valid,
  input logic        line_clk,
  input logic        eol_pulse,
  input logic        evt_wr_accept,
  input logic        evt_line_wrap
);

  // R1
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[3:0] == 4'h0);

  // R3
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_enable && cfg_wr_en) |=> $stable(cfg_rdata));

  // R3
  locked_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_enable |-> !evt_wr_accept);

  // R8
  eol_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eol_pulse |-> line_clk);

  // R8
  eol_ends_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eol_pulse |=> !line_clk && !eol_pulse);

  // R12
  wrap_to_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_line_wrap |=> !pix_valid);

  // R9
  passive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_mode |-> (pclk_en == pix_valid));

  // R10
  active_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_mode && ctl_enable) |-> pclk_en);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable |-> !(pclk_en || pix_valid || line_clk || eol_pulse));

  // R11
  restart_bol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_enable) |-> !pix_valid && !line_clk);

  // R4
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pix_valid, line_clk}));

endmodule

bind lcd_line_timer lcd_line_timer_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ctl_enable    (ctl_enable),
  .active_mode   (active_mode),
  .cfg_wr_en     (cfg_wr_en),
  .cfg_rdata     (cfg_rdata),
  .pclk_en       (pclk_en),
  .pix_valid     (pix_valid),
  .line_clk      (line_clk),
  .eol_pulse     (eol_pulse),
  .evt_wr_accept (evt_wr_accept),
  .evt_line_wrap (evt_line_wrap)
);

// File: tb/test_lcd_line_timer.sv
`timescale 1ns/1ps
module test_lcd_line_timer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_enable;
  logic        active_mode;
  logic        cfg_wr_en;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        pclk_en;
  logic        pix_valid;
  logic        line_clk;
  logic        eol_pulse;

  always #2 clk = ~clk;

  lcd_line_timer i_lcd_line_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_enable  (ctl_enable),
    .active_mode (active_mode),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .pclk_en     (pclk_en),
    .pix_valid   (pix_valid),
    .line_clk    (line_clk),
    .eol_pulse   (eol_pulse)
  );

  typedef struct {
    logic [3:0] v;   // {pclk_en, pix_valid, line_clk, eol_pulse}
    string      req;
  } item_t;

  item_t exp_q[$];
  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard monitor: one expected item per cycle, sampled after the falling edge
  always begin
    @(negedge clk);
    #1;
    if (exp_q.size() > 0) begin
      item_t it;
      logic [3:0] got;
      it  = exp_q.pop_front();
      got = {pclk_en, pix_valid, line_clk, eol_pulse};
      check(got === it.v, it.req, 32'(got), 32'(it.v));
    end
  end

  // driver-side model: push the expected cycles of one line
  task automatic push_line(input logic [31:0] w, input bit act, input int idx, input int cut);
    int len[4];
    int pushed;
    string base;
    pushed = 0;
    len[0] = int'(w[31:24]) + 1;
    len[1] = (int'(w[9:0]) / 16) * 16 + 16;
    len[2] = int'(w[23:16]) + 1;
    len[3] = int'(w[15:10]) + 2;
    for (int ph = 0; ph < 4; ph++) begin
      for (int k = 0; k < len[ph]; k++) begin
        item_t it;
        logic  e;
        if (cut > 0 && pushed == cut) return;
        e = (ph == 3) && (k == len[ph] - 1);
        it.v = {(act || ph == 1), (ph == 1), (ph == 3), e};
        case (ph)
          0: base = "R4";
          1: base = "R5";
          2: base = "R6";
          default: base = e ? "R8" : "R7";
        endcase
        it.req = {base, act ? " R10" : " R9", (idx > 0) ? " R12" : ""};
        exp_q.push_back(it);
        pushed++;
      end
    end
  endtask

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic run_lines(input logic [31:0] w, input bit act, input int nlines,
                           input int cut, input bit poke);
    @(negedge clk);
    for (int i = 0; i < nlines; i++) push_line(w, act, i, (i == nlines - 1) ? cut : 0);
    active_mode = act;
    ctl_enable  = 1'b1;
    if (poke) begin
      repeat (6) @(negedge clk);
      cfg_wr_en = 1'b1;
      cfg_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      cfg_wr_en = 1'b0;
    end
    wait (exp_q.size() == 0);
    @(negedge clk);
    ctl_enable = 1'b0;
    #1;
    // R11: disabled outputs quiet
    check({pclk_en, pix_valid, line_clk, eol_pulse} == 4'h0, "R11",
          32'({pclk_en, pix_valid, line_clk, eol_pulse}), 32'h0);
  endtask

  initial begin
    rst_n       = 1'b0;
    ctl_enable  = 1'b0;
    active_mode = 1'b0;
    cfg_wr_en   = 1'b0;
    cfg_wdata   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(cfg_rdata == 32'h0, "R2", cfg_rdata, 32'h0);
    check({pclk_en, pix_valid, line_clk, eol_pulse} == 4'h0, "R2",
          32'({pclk_en, pix_valid, line_clk, eol_pulse}), 32'h0);

    // R1: field layout, bits 3..0 of pixel count read back as zero
    write_cfg({8'd3, 8'd2, 6'd1, 10'h01F});
    #1;
    check(cfg_rdata == {8'd3, 8'd2, 6'd1, 10'h010}, "R1", cfg_rdata, {8'd3, 8'd2, 6'd1, 10'h010});

    // passive, two back-to-back lines, write attempted mid-line (R3, R12)
    run_lines({8'd3, 8'd2, 6'd1, 10'h01F}, 1'b0, 2, 0, 1'b1);
    check(cfg_rdata == {8'd3, 8'd2, 6'd1, 10'h010}, "R3", cfg_rdata, {8'd3, 8'd2, 6'd1, 10'h010});

    // smallest fields, active mode, eol right after sync start (R8, R10)
    write_cfg(32'h0000_0000);
    #1;
    check(cfg_rdata == 32'h0, "R1", cfg_rdata, 32'h0);
    run_lines(32'h0000_0000, 1'b1, 3, 0, 1'b0);

    // smallest fields, passive mode
    run_lines(32'h0000_0000, 1'b0, 2, 0, 1'b0);

    // abort mid-pixel then restart from the start wait (R11)
    write_cfg({8'd2, 8'd1, 6'd3, 10'h025});
    #1;
    check(cfg_rdata == {8'd2, 8'd1, 6'd3, 10'h020}, "R1", cfg_rdata, {8'd2, 8'd1, 6'd3, 10'h020});
    run_lines({8'd2, 8'd1, 6'd3, 10'h025}, 1'b0, 1, 7, 1'b0);
    repeat (3) @(negedge clk);
    run_lines({8'd2, 8'd1, 6'd3, 10'h025}, 1'b0, 1, 0, 1'b0);

    // largest pixel count and wide waits, active
    write_cfg({8'd255, 8'd255, 6'd63, 10'h3FF});
    #1;
    check(cfg_rdata == {8'd255, 8'd255, 6'd63, 10'h3F0}, "R1", cfg_rdata, {8'd255, 8'd255, 6'd63, 10'h3F0});
    run_lines({8'd255, 8'd255, 6'd63, 10'h3FF}, 1'b1, 1, 0, 1'b0);
    run_lines({8'd255, 8'd255, 6'd63, 10'h3FF}, 1'b0, 1, 0, 1'b1);
    check(cfg_rdata == {8'd255, 8'd255, 6'd63, 10'h3F0}, "R3", cfg_rdata, {8'd255, 8'd255, 6'd63, 10'h3F0});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule